// File: doc/BRIEF.md
# Run-time programmable clock divider with half-duty odd ratios

The block produces a divided clock from its input clock. The integer divisor N can be changed while the block runs, and the output duty cycle stays at 50% for every ratio. Odd ratios use two toggle stages: one changes on rising edges and the other changes on falling edges. Their XOR gives an output whose high and low phases are each N half-cycles long. Even ratios use only the rising-edge stage, which toggles twice per counter cycle. A ratio of one routes the input clock straight to the output. A separate select doubles the overall ratio. The extra factor of two is made by doubling the counter length, so the block never clocks anything from a derived clock.

Software writes a new divisor and the doubling select, then pulses a load strobe. The block holds the new setting as pending. It switches at the next counter wrap, at a moment when the output is low, so every output period stays whole. A locked flag shows that at least one full counter cycle of the current setting has completed.

A small state machine sequences the block. It has four states:
- ST_IDLE: entered on reset.
- ST_BYPASS: the ratio is 1.
- ST_ODD: the ratio is odd and at least 3.
- ST_EVEN: the ratio is even.

It has these transitions:
- ST_IDLE to the mode of the setting captured at reset, on the first rising edge with reset low.
- Any of ST_BYPASS, ST_ODD or ST_EVEN to the mode of the pending setting, on a counter wrap while a setting is pending.
- Any state to ST_IDLE, on reset.

Top module: `clkdiv_top`

## Requirements
- R1: While `rst` is sampled high on two or more consecutive rising edges, `clk_out` and `locked` are low. Reset captures `div_value` and `post_half` as the starting setting. Counting starts at the first rising edge with `rst` low.
- R2: With `post_half` low and an odd divisor N of 3 or more, `clk_out` repeats every N input cycles. It is high for exactly N half-cycles and low for N half-cycles.
- R3: With `post_half` low and an even divisor N, `clk_out` repeats every N input cycles and is high for N/2 cycles. The falling-edge toggle stage holds its value while the block is not in the odd mode.
- R4: With `post_half` low and a divisor of 1, `clk_out` follows `clk_in`. A `div_value` of 0 behaves exactly as 1.
- R5: With `post_half` high, the overall ratio is 2N (N = 1 when `div_value` is 0). The output is high for N cycles and low for N cycles.
- R6: A rising edge with `div_load` high captures `div_value` and `post_half` as a pending setting. The pending setting takes effect on the first counter wrap after the capture. A counter wrap is the rising edge that ends count len-1, where len is N, 2N, or 1 in bypass. Every output period before and after the switch is whole, with equal high and low time.
- R7: `locked` clears on reset and on the wrap edge that applies a new setting. It rises on the len-th rising edge after the edge that starts the setting. After reset, that start edge is the first rising edge with `rst` low; after a switch, it is the applying wrap edge.
- R8: A second load before the wrap replaces the earlier pending setting. Only the last captured setting is ever applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| div_value | input | DIV_W | Divisor N (0 is treated as 1) |
| div_load | input | 1 | One-cycle strobe that captures `div_value` and `post_half` |
| post_half | input | 1 | Doubles the overall ratio when high |
| clk_out | output | 1 | Divided clock |
| locked | output | 1 | High once a full counter cycle of the current setting has completed |

## Verification
The properties assume that `rst` is held for at least two rising edges with `div_value` and `post_half` steady. They also assume that inputs change only between edges, well clear of both the rising and the falling edge, because the falling-edge stages sample reset too. The stimulus meets this by driving every input shortly after a rising edge and by holding reset for four edges with the setting fixed. Output samples are taken a quarter period after each clock edge. Each whole period is scored by its high and low run lengths, in half-cycles, against a queue of expected ratios. A runt pulse or an early switch therefore shows up as an unequal or unexpected run length.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Sequencer states: idle after reset, then one state per output mode.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_BYPASS = 2'd1,
        ST_ODD    = 2'd2,
        ST_EVEN   = 2'd3
    } dv_state_e;

endpackage

// File: rtl/clkdiv_decode.sv
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int LEN_W = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_value,
    input  logic             post_half,
    output dv_state_e        dec_mode,
    output logic [LEN_W-1:0] dec_len,
    output logic [LEN_W-1:0] dec_mark
);

    logic [DIV_W-1:0] n_eff;

    // Map a raw divisor and the doubling select onto a mode, a counter
    // length and the count at which the second toggle point sits.
    always_comb begin
        n_eff = (div_value == '0) ? DIV_W'(1) : div_value;
        if (post_half) begin
            // Doubled ratio: always even, second toggle at count N.
            dec_mode = ST_EVEN;
            dec_len  = {n_eff, 1'b0};
            dec_mark = LEN_W'(n_eff);
        end else if (n_eff == DIV_W'(1)) begin
            dec_mode = ST_BYPASS;
            dec_len  = LEN_W'(1);
            dec_mark = '0;
        end else if (n_eff[0]) begin
            // Odd: falling-edge stage fires at 1 + (N-1)/2.
            dec_mode = ST_ODD;
            dec_len  = LEN_W'(n_eff);
            dec_mark = LEN_W'(n_eff >> 1) + LEN_W'(1);
        end else begin
            dec_mode = ST_EVEN;
            dec_len  = LEN_W'(n_eff);
            dec_mark = LEN_W'(n_eff >> 1);
        end
    end

endmodule

// File: rtl/clkdiv_toggle.sv
module clkdiv_toggle #(
    parameter bit ON_FALL = 1'b0
) (
    input  logic clk_in,
    input  logic rst,
    input  logic en,
    output logic q
);

    // One toggle stage; the parameter picks the clock edge it uses.
    generate
        if (ON_FALL) begin : g_fall
            always_ff @(negedge clk_in) begin
                if (rst)     q <= 1'b0;
                else if (en) q <= ~q;
            end
        end else begin : g_rise
            always_ff @(posedge clk_in) begin
                if (rst)     q <= 1'b0;
                else if (en) q <= ~q;
            end
        end
    endgenerate

endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic             load,
    input  dv_state_e        dec_mode,
    input  logic [LEN_W-1:0] dec_len,
    input  logic [LEN_W-1:0] dec_mark,
    output dv_state_e        state,
    output logic [LEN_W-1:0] cnt,
    output logic [LEN_W-1:0] act_len,
    output logic             wrap,
    output logic             locked,
    output logic             en_rise,
    output logic             en_fall
);

    dv_state_e        nxt;
    dv_state_e        act_mode;
    dv_state_e        pend_mode;
    logic [LEN_W-1:0] act_mark;
    logic [LEN_W-1:0] pend_len;
    logic [LEN_W-1:0] pend_mark;
    logic             pend_v;
    logic             apply;

    assign wrap  = (state != ST_IDLE) && (cnt == act_len - LEN_W'(1));
    assign apply = wrap && pend_v;

    // State register.
    always_ff @(posedge clk_in) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:                    nxt = act_mode;
            ST_BYPASS, ST_ODD, ST_EVEN: if (apply) nxt = pend_mode;
        endcase
    end

    // Toggle enables per state.
    always_comb begin
        en_rise = 1'b0;
        en_fall = 1'b0;
        unique case (state)
            ST_IDLE, ST_BYPASS: ;
            ST_ODD: begin
                en_rise = (cnt == '0);
                en_fall = (cnt == act_mark);
            end
            ST_EVEN: en_rise = (cnt == '0) || (cnt == act_mark);
        endcase
    end

    // Counter, active and pending settings, lock flag.
    always_ff @(posedge clk_in) begin
        if (rst) begin
            cnt       <= '0;
            act_mode  <= dec_mode;
            act_len   <= dec_len;
            act_mark  <= dec_mark;
            pend_mode <= dec_mode;
            pend_len  <= dec_len;
            pend_mark <= dec_mark;
            pend_v    <= 1'b0;
            locked    <= 1'b0;
        end else begin
            if (state == ST_IDLE || wrap) cnt <= '0;
            else                          cnt <= cnt + LEN_W'(1);

            if (apply) begin
                act_mode <= pend_mode;
                act_len  <= pend_len;
                act_mark <= pend_mark;
            end

            if (load) begin
                pend_v    <= 1'b1;
                pend_mode <= dec_mode;
                pend_len  <= dec_len;
                pend_mark <= dec_mark;
            end else if (apply) begin
                pend_v <= 1'b0;
            end

            if (apply)     locked <= 1'b0;
            else if (wrap) locked <= 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
    import clkdiv_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_value,
    input  logic             div_load,
    input  logic             post_half,
    output logic             clk_out,
    output logic             locked
);

    localparam int LEN_W = DIV_W + 1;

    dv_state_e        dec_mode;
    dv_state_e        state;
    logic [LEN_W-1:0] dec_len;
    logic [LEN_W-1:0] dec_mark;
    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] act_len;
    logic             wrap;
    logic             en_rise;
    logic             en_fall;
    logic             q_a;
    logic             q_b;
    logic             bypass_sel;

    clkdiv_decode #(.DIV_W(DIV_W), .LEN_W(LEN_W)) u_dec (
        .div_value (div_value),
        .post_half (post_half),
        .dec_mode  (dec_mode),
        .dec_len   (dec_len),
        .dec_mark  (dec_mark)
    );

    clkdiv_fsm #(.LEN_W(LEN_W)) u_fsm (
        .clk_in   (clk_in),
        .rst      (rst),
        .load     (div_load),
        .dec_mode (dec_mode),
        .dec_len  (dec_len),
        .dec_mark (dec_mark),
        .state    (state),
        .cnt      (cnt),
        .act_len  (act_len),
        .wrap     (wrap),
        .locked   (locked),
        .en_rise  (en_rise),
        .en_fall  (en_fall)
    );

    clkdiv_toggle #(.ON_FALL(1'b0)) u_tog_rise (
        .clk_in (clk_in),
        .rst    (rst),
        .en     (en_rise),
        .q      (q_a)
    );

    clkdiv_toggle #(.ON_FALL(1'b1)) u_tog_fall (
        .clk_in (clk_in),
        .rst    (rst),
        .en     (en_fall),
        .q      (q_b)
    );

    // Bypass select is retimed on the falling edge, so the output mux
    // only switches while the input clock and the toggle XOR are low.
    always_ff @(negedge clk_in) begin
        if (rst) bypass_sel <= 1'b0;
        else     bypass_sel <= (state == ST_BYPASS);
    end

    assign clk_out = bypass_sel ? clk_in : (q_a ^ q_b);

endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
    import clkdiv_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input logic             clk_in,
    input logic             rst,
    input dv_state_e        state,
    input logic [LEN_W-1:0] cnt,
    input logic [LEN_W-1:0] act_len,
    input logic             wrap,
    input logic             locked,
    input logic             q_b,
    input logic             clk_out
);

    logic rst_q;

    always_ff @(posedge clk_in) rst_q <= rst;

    always @(posedge clk_in) begin
        if (rst_q && rst) begin
            AST_RESET_QUIET: assert (!clk_out && !locked); // R1
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk_in) disable iff (rst)
        cnt < act_len); // R2

    AST_FALL_STAGE_HELD: assert property (@(posedge clk_in) disable iff (rst)
        (state != ST_ODD && $past(state) != ST_ODD) |-> $stable(q_b)); // R3

    AST_SWITCH_AT_WRAP: assert property (@(posedge clk_in) disable iff (rst)
        (act_len != $past(act_len)) |-> $past(wrap)); // R6

    AST_LOCK_AT_WRAP: assert property (@(posedge clk_in) disable iff (rst)
        $rose(locked) |-> $past(wrap)); // R7

endmodule

bind clkdiv_top clkdiv_checker #(.LEN_W(LEN_W)) u_chk (
    .clk_in  (clk_in),
    .rst     (rst),
    .state   (state),
    .cnt     (cnt),
    .act_len (act_len),
    .wrap    (wrap),
    .locked  (locked),
    .q_b     (q_b),
    .clk_out (clk_out)
);

// File: tb/tb_clkdiv_top.sv
module tb_clkdiv_top;

    localparam int CLK_PERIOD = 20;
    localparam int DIV_W      = 8;

    logic             clk_in    = 1'b0;
    logic             rst       = 1'b1;
    logic [DIV_W-1:0] div_value = '0;
    logic             div_load  = 1'b0;
    logic             post_half = 1'b0;
    wire              clk_out;
    wire              locked;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    // Scoreboard: expected ratios in order, with the requirement each serves.
    int    exp_q[$];
    string tag_q[$];
    bit    mon_en  = 1'b0;
    logic  m_prev  = 1'b0;
    bit    m_started = 1'b0;
    int    m_high  = 0;
    int    m_low   = 0;
    int    m_count = 0;

    always #(CLK_PERIOD/2) clk_in = ~clk_in;

    clkdiv_top #(.DIV_W(DIV_W)) dut (
        .clk_in    (clk_in),
        .rst       (rst),
        .div_value (div_value),
        .div_load  (div_load),
        .post_half (post_half),
        .clk_out   (clk_out),
        .locked    (locked)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Score one whole output period (high and low runs in half-cycles).
    task automatic mon_score();
        if (exp_q.size() == 0) return;
        if ((m_high != exp_q[0] || m_low != exp_q[0]) && exp_q.size() > 1
            && m_high == exp_q[1] && m_low == exp_q[1]) begin
            void'(exp_q.pop_front());
            void'(tag_q.pop_front());
        end
        check(m_high == exp_q[0], tag_q[0], "high half-cycles", m_high, exp_q[0]);
        check(m_low  == exp_q[0], tag_q[0], "low half-cycles",  m_low,  exp_q[0]);
        m_count++;
    endtask

    task automatic mon_sample();
        logic s;
        s = clk_out;
        if (!mon_en) begin
            m_started = 1'b0;
        end else if (s && !m_prev) begin
            if (m_started) mon_score();
            m_started = 1'b1;
            m_high    = 1;
            m_low     = 0;
        end else if (m_started) begin
            if (s) m_high++;
            else   m_low++;
        end
        m_prev = s;
    endtask

    // Monitor: samples a quarter period after each clock edge.
    initial begin
        forever begin
            @(posedge clk_in);
            #(CLK_PERIOD/4);
            mon_sample();
            #(CLK_PERIOD/2);
            mon_sample();
        end
    end

    task automatic start_monitor(input int ratio, input string tag);
        #1;
        exp_q.push_back(ratio);
        tag_q.push_back(tag);
        m_count = 0;
        mon_en  = 1'b1;
    endtask

    task automatic apply_reset(input int n, input bit ph);
        mon_en = 1'b0;
        exp_q.delete();
        tag_q.delete();
        @(posedge clk_in); #3;
        rst       = 1'b1;
        div_value = DIV_W'(n);
        post_half = ph;
        div_load  = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk_in); #5;
            if (i > 0) begin
                check(clk_out == 1'b0, "R1", "clk_out high phase in reset", clk_out, 0);
                check(locked  == 1'b0, "R1", "locked in reset", locked, 0);
            end
            #10;
            if (i > 0)
                check(clk_out == 1'b0, "R1", "clk_out low phase in reset", clk_out, 0);
        end
        @(posedge clk_in); #3;
        rst = 1'b0;
    endtask

    task automatic wait_lock(input int len);
        int k;
        k = 0;
        do begin
            @(posedge clk_in); #5;
            k++;
        end while (!locked && k < 4*len + 8);
        check(k == len + 1, "R7", "edges until locked", k, len + 1);
    endtask

    task automatic do_load(input int n, input bit ph, input int ratio, input string tag);
        @(posedge clk_in); #3;
        div_value = DIV_W'(n);
        post_half = ph;
        div_load  = 1'b1;
        @(posedge clk_in); #3;
        div_load  = 1'b0;
        exp_q.push_back(ratio);
        tag_q.push_back(tag);
    endtask

    task automatic end_run(input int ratio, input string tag);
        int front;
        front = (exp_q.size() > 0) ? exp_q[0] : -1;
        check(exp_q.size() == 1, tag, "ratios left in queue", exp_q.size(), 1);
        check(front == ratio, tag, "final ratio", front, ratio);
        check(m_count >= 3, tag, "whole periods seen", m_count, 3);
        mon_en = 1'b0;
    endtask

    task automatic run_cfg(input int n, input bit ph, input int ratio, input string tag);
        apply_reset(n, ph);
        wait_lock(ratio);
        start_monitor(ratio, tag);
        repeat (ratio * 6 + 4) @(posedge clk_in);
        #5;
        end_run(ratio, tag);
    endtask

    initial begin
        // Fixed ratios from reset.
        run_cfg(3,   1'b0, 3,   "R2");
        run_cfg(5,   1'b0, 5,   "R2");
        run_cfg(7,   1'b0, 7,   "R2");
        run_cfg(255, 1'b0, 255, "R2");
        run_cfg(2,   1'b0, 2,   "R3");
        run_cfg(4,   1'b0, 4,   "R3");
        run_cfg(6,   1'b0, 6,   "R3");
        run_cfg(1,   1'b0, 1,   "R4");
        run_cfg(0,   1'b0, 1,   "R4");
        run_cfg(3,   1'b1, 6,   "R5");
        run_cfg(1,   1'b1, 2,   "R5");
        run_cfg(0,   1'b1, 2,   "R5");
        run_cfg(4,   1'b1, 8,   "R5");
        run_cfg(255, 1'b1, 510, "R5");

        // Switch 5 -> 3: capture at edge 7, apply at wrap edge 10.
        apply_reset(5, 1'b0);
        wait_lock(5);
        start_monitor(5, "R2");
        @(posedge clk_in); #3;
        div_value = DIV_W'(3);
        div_load  = 1'b1;
        @(posedge clk_in); #3;
        div_load  = 1'b0;
        exp_q.push_back(3);
        tag_q.push_back("R6");
        for (int j = 8; j <= 14; j++) begin
            @(posedge clk_in); #5;
            check(locked == ((j < 10) || (j >= 13)), "R7", "locked around switch",
                  locked, ((j < 10) || (j >= 13)));
        end
        repeat (24) @(posedge clk_in);
        #5;
        end_run(3, "R6");

        // Chain through bypass: 3 -> 1 -> 4, then 4 -> 3 doubled.
        apply_reset(3, 1'b0);
        wait_lock(3);
        start_monitor(3, "R6");
        do_load(1, 1'b0, 1, "R6");
        repeat (12) @(posedge clk_in);
        do_load(4, 1'b0, 4, "R6");
        repeat (30) @(posedge clk_in);
        do_load(3, 1'b1, 6, "R6");
        repeat (40) @(posedge clk_in);
        #5;
        end_run(6, "R6");

        // Last load wins: 7 captured at edge 6, 2 at edge 7, wrap at edge 8.
        apply_reset(4, 1'b0);
        wait_lock(4);
        start_monitor(4, "R8");
        @(posedge clk_in); #3;
        div_value = DIV_W'(7);
        div_load  = 1'b1;
        @(posedge clk_in); #3;
        div_value = DIV_W'(2);
        @(posedge clk_in); #3;
        div_load  = 1'b0;
        exp_q.push_back(2);
        tag_q.push_back("R8");
        repeat (30) @(posedge clk_in);
        #5;
        end_run(2, "R8");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

endmodule